// File: doc/BRIEF.md
# Transactional Undo Log Buffer

This block keeps the prior contents of cache lines that a transaction updates in place. Before the cache controller writes a line inside a transaction, it hands the block the line address and the line's current data. The block asks for exclusive permission on that line through a request/grant handshake. Once permission is granted and the old value is safe, it pulses a go signal. Only the first write to a line inside a transaction is recorded. Later writes to the same line are let through without a new entry.

A small on-chip store holds the first `DEPTH` old values. Entries beyond that go to a log region in memory. Each such entry takes a memory write request of its own, and the old value is held until memory grants the request, which means the log line has been allocated. On abort, every recorded line is replayed on a restore port, newest first. Entries that were spilled are read back from the log region before they are replayed. A one-cycle done pulse follows the last replay. On commit, all entries are dropped and the spill pointer returns to the log base, with no memory traffic.

Top module: `ulog_buffer`

## Requirements
- R1: After reset, `log_ready_o` is high and `perm_req_o`, `wr_go_o`, `mem_req_o`, `rb_valid_o` and `rb_done_o` are all low.
- R2: After a log request is accepted, `perm_req_o` rises with `perm_addr_o` equal to the request address. It holds both steady until `perm_gnt_i`. `wr_go_o` pulses for exactly one cycle per accepted request, and only after the grant.
- R3: A request whose address is already recorded in the current transaction adds no entry. It causes no memory traffic and no extra replay on abort, and the value kept is the first one.
- R4: The first `DEPTH` distinct lines of a transaction are kept on chip and cause no memory traffic.
- R5: Distinct line number `DEPTH+k` (k counting from 0) is written to memory at address `LOG_BASE + k*LINE_BYTES` with `mem_we_o`=1 and its old data. The request stays steady until `mem_gnt_i`, and `wr_go_o` follows only after that grant.
- R6: While `DEPTH+SPILL_DEPTH` lines are recorded, `log_ready_o` stays low, so no request is accepted and no go pulse is issued.
- R7: On abort, each recorded line is presented once on `rb_valid_o`/`rb_addr_o`/`rb_data_o` in reverse recording order. A spilled entry is first fetched with a read request (`mem_we_o`=0) at its log address.
- R8: `rb_done_o` pulses for one cycle, in the cycle after the last replay. When nothing is recorded, it pulses with no replay at all. Afterwards the log is empty.
- R9: Commit empties the log without any memory request. A later abort replays nothing, and the next spill goes to `LOG_BASE` again.
- R10: Commit and abort are acted on only while idle. When both are asserted in the same cycle, abort wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| log_valid_i | input | 1 | Log request from the cache controller |
| log_addr_i | input | ADDR_W | Line address to be written |
| log_data_i | input | DATA_W | Current (old) line contents |
| log_ready_o | output | 1 | Request accepted this cycle |
| perm_req_o | output | 1 | Exclusive permission request |
| perm_addr_o | output | ADDR_W | Line for the permission request |
| perm_gnt_i | input | 1 | Permission granted |
| wr_go_o | output | 1 | Transactional write may proceed |
| mem_req_o | output | 1 | Log-region memory request |
| mem_we_o | output | 1 | 1 = spill write, 0 = rollback read |
| mem_addr_o | output | ADDR_W | Log-region address |
| mem_wdata_o | output | DATA_W | Old value being spilled |
| mem_gnt_i | input | 1 | Memory request done (line allocated / data valid) |
| mem_rdata_i | input | DATA_W | Read data for rollback fetch |
| commit_i | input | 1 | Transaction commit |
| abort_i | input | 1 | Transaction abort |
| rb_valid_o | output | 1 | Restore strobe |
| rb_addr_o | output | ADDR_W | Line to restore |
| rb_data_o | output | DATA_W | Old value to write back |
| rb_done_o | output | 1 | Rollback finished |

## Verification
The bench uses `DEPTH`=2 and `SPILL_DEPTH`=2, with 32-bit data and 16-bit addresses. With these values a handful of requests is enough to fill the on-chip store, spill into both log slots and reach the full condition. That makes the spill addresses, the stall when full, the mixed on-chip and fetched replay order and the reset of the spill pointer after commit all cheap to exercise. The permission and memory responders answer with a delay of several cycles, so the hold-until-grant behaviour is exercised on every handshake.

// File: rtl/ulog_pkg.sv
package ulog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PERM,
    ST_SPILL,
    ST_GO,
    ST_FETCH,
    ST_RESTORE,
    ST_DONE
  } ulog_state_e;
endpackage

// File: rtl/ulog_tag_cam.sv
module ulog_tag_cam #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 5,
  parameter int IDX_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  valid_cnt_i,
  input  logic [ADDR_W-1:0] cmp_addr_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic [ADDR_W-1:0] tag_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tag_q[i] <= '0;
      else if (wr_en_i && wr_idx_i == CNT_W'(i)) tag_q[i] <= wr_addr_i;
    end
    // only entries below the fill level take part in the lookup
    assign match[i] = (CNT_W'(i) < valid_cnt_i) && (tag_q[i] == cmp_addr_i);
  end

  assign hit_o = |match;

  always_comb begin
    rd_addr_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (rd_idx_i == IDX_W'(i)) rd_addr_o = tag_q[i];
  end
endmodule

// File: rtl/ulog_data_store.sv
module ulog_data_store #(
  parameter int DATA_W = 512,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 5,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (wr_en_i && wr_idx_i == CNT_W'(i)) mem_q[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx_i == IDX_W'(i)) rd_data_o = mem_q[i];
  end
endmodule

// File: rtl/ulog_ctrl.sv
module ulog_ctrl
  import ulog_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 512,
  parameter int          DEPTH      = 8,
  parameter int          TOTAL      = 64,
  parameter int          LINE_BYTES = 64,
  parameter logic [63:0] LOG_BASE   = 64'h0010_0000,
  parameter int          CNT_W      = 7,
  parameter int          IDX_W      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              log_valid_i,
  input  logic [ADDR_W-1:0] log_addr_i,
  input  logic [DATA_W-1:0] log_data_i,
  output logic              log_ready_o,
  output logic              perm_req_o,
  output logic [ADDR_W-1:0] perm_addr_o,
  input  logic              perm_gnt_i,
  output logic              wr_go_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              commit_i,
  input  logic              abort_i,
  output logic              rb_valid_o,
  output logic [ADDR_W-1:0] rb_addr_o,
  output logic [DATA_W-1:0] rb_data_o,
  output logic              rb_done_o,
  input  logic              cam_hit_i,
  input  logic [ADDR_W-1:0] cam_rd_addr_i,
  input  logic [DATA_W-1:0] dat_rd_i,
  output logic              tag_we_o,
  output logic              dat_we_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] cmp_addr_o,
  output logic [DATA_W-1:0] stage_data_o,
  output logic [IDX_W-1:0]  rd_idx_o
);
  ulog_state_e       state_q;
  logic [CNT_W-1:0]  count_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  logic              room_onchip, full, idx_onchip;
  logic [CNT_W-1:0]  last_ent, slot;
  logic [IDX_W-1:0]  idx_m1;
  logic              new_line;

  assign room_onchip = count_q < CNT_W'(DEPTH);
  assign full        = count_q >= CNT_W'(TOTAL);
  assign idx_onchip  = CNT_W'(idx_q) < CNT_W'(DEPTH);
  assign last_ent    = count_q - CNT_W'(1);
  assign idx_m1      = idx_q - IDX_W'(1);
  assign new_line    = (state_q == ST_PERM) && perm_gnt_i && !cam_hit_i;

  assign log_ready_o = (state_q == ST_IDLE) && !commit_i && !abort_i && !full;
  assign perm_req_o  = (state_q == ST_PERM);
  assign perm_addr_o = addr_q;
  assign wr_go_o     = (state_q == ST_GO);

  // spill slot is the write pointer past the on-chip part; fetch slot is the replay index
  assign slot = (state_q == ST_SPILL) ? count_q - CNT_W'(DEPTH)
                                      : CNT_W'(idx_q) - CNT_W'(DEPTH);
  assign mem_req_o   = (state_q == ST_SPILL) || (state_q == ST_FETCH);
  assign mem_we_o    = (state_q == ST_SPILL);
  assign mem_addr_o  = ADDR_W'(LOG_BASE) + ADDR_W'(slot) * ADDR_W'(LINE_BYTES);
  assign mem_wdata_o = data_q;

  assign rb_valid_o = (state_q == ST_RESTORE);
  assign rb_addr_o  = cam_rd_addr_i;
  assign rb_data_o  = idx_onchip ? dat_rd_i : data_q;
  assign rb_done_o  = (state_q == ST_DONE);

  assign dat_we_o     = new_line && room_onchip;
  assign tag_we_o     = dat_we_o || ((state_q == ST_SPILL) && mem_gnt_i);
  assign cnt_o        = count_q;
  assign cmp_addr_o   = addr_q;
  assign stage_data_o = data_q;
  assign rd_idx_o     = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      count_q <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (abort_i) begin
            if (count_q == '0) state_q <= ST_DONE;
            else begin
              idx_q   <= IDX_W'(last_ent);
              state_q <= (last_ent >= CNT_W'(DEPTH)) ? ST_FETCH : ST_RESTORE;
            end
          end else if (commit_i) begin
            count_q <= '0;
          end else if (log_valid_i && !full) begin
            addr_q  <= log_addr_i;
            data_q  <= log_data_i;
            state_q <= ST_PERM;
          end
        end
        ST_PERM: begin
          if (perm_gnt_i) begin
            if (cam_hit_i) state_q <= ST_GO;
            else if (room_onchip) begin
              count_q <= count_q + CNT_W'(1);
              state_q <= ST_GO;
            end else state_q <= ST_SPILL;
          end
        end
        ST_SPILL: begin
          if (mem_gnt_i) begin
            count_q <= count_q + CNT_W'(1);
            state_q <= ST_GO;
          end
        end
        ST_GO: state_q <= ST_IDLE;
        ST_FETCH: begin
          if (mem_gnt_i) begin
            data_q  <= mem_rdata_i;
            state_q <= ST_RESTORE;
          end
        end
        ST_RESTORE: begin
          if (idx_q == '0) begin
            count_q <= '0;
            state_q <= ST_DONE;
          end else begin
            idx_q   <= idx_m1;
            state_q <= (CNT_W'(idx_m1) >= CNT_W'(DEPTH)) ? ST_FETCH : ST_RESTORE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ulog_buffer.sv
module ulog_buffer #(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 512,
  parameter int          DEPTH       = 8,
  parameter int          SPILL_DEPTH = 56,
  parameter int          LINE_BYTES  = 64,
  parameter logic [63:0] LOG_BASE    = 64'h0010_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              log_valid_i,
  input  logic [ADDR_W-1:0] log_addr_i,
  input  logic [DATA_W-1:0] log_data_i,
  output logic              log_ready_o,
  output logic              perm_req_o,
  output logic [ADDR_W-1:0] perm_addr_o,
  input  logic              perm_gnt_i,
  output logic              wr_go_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              commit_i,
  input  logic              abort_i,
  output logic              rb_valid_o,
  output logic [ADDR_W-1:0] rb_addr_o,
  output logic [DATA_W-1:0] rb_data_o,
  output logic              rb_done_o
);
  localparam int TOTAL = DEPTH + SPILL_DEPTH;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam int IDX_W = $clog2(TOTAL);

  logic              cam_hit, tag_we, dat_we;
  logic [ADDR_W-1:0] cam_rd_addr, cmp_addr;
  logic [DATA_W-1:0] dat_rd, stage_data;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  rd_idx;

  ulog_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .TOTAL(TOTAL),
    .LINE_BYTES(LINE_BYTES), .LOG_BASE(LOG_BASE), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .log_valid_i, .log_addr_i, .log_data_i, .log_ready_o,
    .perm_req_o, .perm_addr_o, .perm_gnt_i, .wr_go_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_gnt_i, .mem_rdata_i,
    .commit_i, .abort_i, .rb_valid_o, .rb_addr_o, .rb_data_o, .rb_done_o,
    .cam_hit_i(cam_hit), .cam_rd_addr_i(cam_rd_addr), .dat_rd_i(dat_rd),
    .tag_we_o(tag_we), .dat_we_o(dat_we), .cnt_o(cnt), .cmp_addr_o(cmp_addr),
    .stage_data_o(stage_data), .rd_idx_o(rd_idx)
  );

  ulog_tag_cam #(
    .ADDR_W(ADDR_W), .ENTRIES(TOTAL), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_cam (
    .clk_i, .rst_ni, .wr_en_i(tag_we), .wr_idx_i(cnt), .wr_addr_i(cmp_addr),
    .valid_cnt_i(cnt), .cmp_addr_i(cmp_addr), .rd_idx_i(rd_idx),
    .hit_o(cam_hit), .rd_addr_o(cam_rd_addr)
  );

  ulog_data_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i, .rst_ni, .wr_en_i(dat_we), .wr_idx_i(cnt), .wr_data_i(stage_data),
    .rd_idx_i(rd_idx), .rd_data_o(dat_rd)
  );
endmodule

// File: rtl/ulog_buffer_chk.sv
module ulog_buffer_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 512
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              log_ready_o,
  input logic              perm_req_o,
  input logic [ADDR_W-1:0] perm_addr_o,
  input logic              perm_gnt_i,
  input logic              wr_go_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_gnt_i,
  input logic              commit_i,
  input logic              abort_i,
  input logic              rb_valid_o,
  input logic              rb_done_o
);
  logic granted_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) granted_q <= 1'b0;
    else if (perm_req_o && perm_gnt_i) granted_q <= 1'b1;
    else if (wr_go_o) granted_q <= 1'b0;
  end

  assert_go_after_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go_o |-> granted_q);

  assert_perm_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_req_o && !perm_gnt_i |=> perm_req_o && $stable(perm_addr_o));

  assert_mem_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_we_o)
                               && $stable(mem_addr_o) && $stable(mem_wdata_o));

  assert_one_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_go_o, rb_valid_o, rb_done_o}));

  assert_no_accept_in_rollback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_valid_o |-> !log_ready_o);

  assert_commit_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !abort_i && !perm_req_o && !mem_req_o && !rb_valid_o && !wr_go_o
      && !rb_done_o |=> !mem_req_o);

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_done_o |=> !rb_done_o);
endmodule

bind ulog_buffer ulog_buffer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .log_ready_o, .perm_req_o, .perm_addr_o, .perm_gnt_i, .wr_go_o,
  .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_gnt_i,
  .commit_i, .abort_i, .rb_valid_o, .rb_done_o
);

// File: tb/ulog_buffer_test.sv
module ulog_buffer_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LB = 64;
  localparam logic [15:0] BASE = 16'h8000;

  logic clk_i = 0, rst_ni = 0;
  logic log_valid_i = 0, perm_gnt_i = 0, mem_gnt_i = 0, commit_i = 0, abort_i = 0;
  logic [AW-1:0] log_addr_i = '0;
  logic [DW-1:0] log_data_i = '0, mem_rdata_i = '0;
  logic log_ready_o, perm_req_o, wr_go_o, mem_req_o, mem_we_o, rb_valid_o, rb_done_o;
  logic [AW-1:0] perm_addr_o, mem_addr_o, rb_addr_o;
  logic [DW-1:0] mem_wdata_o, rb_data_o;

  int checks = 0, fails = 0;
  int pdly = 0, mdly = 0, mem_wr_cnt = 0, mem_rd_cnt = 0;
  logic [AW-1:0] last_gnt_addr = '0;
  logic [DW-1:0] sw_mem [int];
  logic [AW-1:0] rq_addr[$];
  logic [DW-1:0] rq_data[$];

  ulog_buffer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(2), .SPILL_DEPTH(2),
                .LINE_BYTES(LB), .LOG_BASE(64'(BASE))) uut (.*);

  always #5 clk_i = ~clk_i;

  // permission responder: two-cycle wait
  always @(negedge clk_i) begin
    perm_gnt_i <= 1'b0;
    if (perm_req_o && !perm_gnt_i) begin
      if (pdly >= 1) begin perm_gnt_i <= 1'b1; pdly <= 0; last_gnt_addr <= perm_addr_o; end
      else pdly <= pdly + 1;
    end
  end

  // log-region memory responder: three-cycle wait
  always @(negedge clk_i) begin
    mem_gnt_i <= 1'b0;
    if (mem_req_o && !mem_gnt_i) begin
      if (mdly >= 2) begin
        mem_gnt_i <= 1'b1; mdly <= 0;
        if (mem_we_o) begin sw_mem[int'(mem_addr_o)] = mem_wdata_o; mem_wr_cnt <= mem_wr_cnt + 1; end
        else begin mem_rdata_i <= sw_mem[int'(mem_addr_o)]; mem_rd_cnt <= mem_rd_cnt + 1; end
      end else mdly <= mdly + 1;
    end
  end

  always @(negedge clk_i) if (rb_valid_o) begin rq_addr.push_back(rb_addr_o); rq_data.push_back(rb_data_o); end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic log_line(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    int n; bit got;
    @(negedge clk_i); log_valid_i = 1; log_addr_i = a; log_data_i = d;
    n = 0; while (!log_ready_o && n < 50) begin @(negedge clk_i); n++; end
    @(negedge clk_i); log_valid_i = 0;
    got = 0; n = 0;
    while (!got && n < 60) begin
      if (wr_go_o) got = 1; else begin @(negedge clk_i); n++; end
    end
    chk(got, {req, " go"}, 64'(got), 1);
    chk(last_gnt_addr == a, "R2 grant addr", 64'(last_gnt_addr), 64'(a));
    @(negedge clk_i);
    chk(!wr_go_o, "R2 go single", 64'(wr_go_o), 0);
  endtask

  task automatic do_abort(input bit with_commit);
    int n;
    rq_addr.delete(); rq_data.delete();
    @(negedge clk_i); abort_i = 1; commit_i = with_commit;
    @(negedge clk_i); abort_i = 0; commit_i = 0;
    n = 0; while (!rb_done_o && n < 200) begin @(negedge clk_i); n++; end
    chk(rb_done_o, "R8 done seen", 64'(rb_done_o), 1);
    @(negedge clk_i);
    chk(!rb_done_o, "R8 done one cycle", 64'(rb_done_o), 0);
  endtask

  task automatic t_reset;
    chk(log_ready_o, "R1 ready", 64'(log_ready_o), 1);
    chk(!perm_req_o && !wr_go_o && !mem_req_o && !rb_valid_o && !rb_done_o, "R1 idle outs",
        64'({perm_req_o, wr_go_o, mem_req_o, rb_valid_o, rb_done_o}), 0);
  endtask

  task automatic t_fill_spill_rollback;
    logic [AW-1:0] ea[4] = '{16'h0100, 16'h0140, 16'h0180, 16'h01C0};
    logic [DW-1:0] ed[4] = '{32'hA0A0_0001, 32'hB0B0_0002, 32'hC0C0_0003, 32'hD0D0_0004};
    int w0; bit quiet;
    w0 = mem_wr_cnt;
    log_line(ea[0], ed[0], "R4");
    log_line(ea[1], ed[1], "R4");
    chk(mem_wr_cnt == w0, "R4 no mem on chip", 64'(mem_wr_cnt), 64'(w0));
    log_line(ea[2], ed[2], "R5");
    chk(mem_wr_cnt == w0 + 1, "R5 spill write", 64'(mem_wr_cnt), 64'(w0 + 1));
    chk(sw_mem[int'(BASE)] == ed[2], "R5 slot0 data", 64'(sw_mem[int'(BASE)]), 64'(ed[2]));
    log_line(ea[0], 32'hFFFF_FFFF, "R3");
    chk(mem_wr_cnt == w0 + 1, "R3 dup no spill", 64'(mem_wr_cnt), 64'(w0 + 1));
    log_line(ea[3], ed[3], "R5");
    chk(sw_mem[int'(BASE) + LB] == ed[3], "R5 slot1 data", 64'(sw_mem[int'(BASE) + LB]), 64'(ed[3]));
    // full: request must not be taken
    @(negedge clk_i); log_valid_i = 1; log_addr_i = 16'h0200; log_data_i = 32'h1234;
    quiet = 1;
    for (int i = 0; i < 8; i++) begin
      if (log_ready_o || wr_go_o || perm_req_o) quiet = 0;
      @(negedge clk_i);
    end
    log_valid_i = 0;
    chk(quiet, "R6 full stall", 64'(quiet), 1);
    w0 = mem_rd_cnt;
    do_abort(0);
    chk(rq_addr.size() == 4, "R7 replay count", 64'(rq_addr.size()), 4);
    chk(mem_rd_cnt == w0 + 2, "R7 fetch reads", 64'(mem_rd_cnt), 64'(w0 + 2));
    for (int i = 0; i < 4; i++) begin
      if (rq_addr.size() > i) begin
        chk(rq_addr[i] == ea[3 - i], "R7 reverse addr", 64'(rq_addr[i]), 64'(ea[3 - i]));
        chk(rq_data[i] == ed[3 - i], "R3 R7 first value", 64'(rq_data[i]), 64'(ed[3 - i]));
      end
    end
    do_abort(0);
    chk(rq_addr.size() == 0, "R8 empty rollback", 64'(rq_addr.size()), 0);
  endtask

  task automatic t_commit;
    int w0, r0;
    log_line(16'h0300, 32'h0000_0031, "R9");
    log_line(16'h0340, 32'h0000_0032, "R9");
    log_line(16'h0380, 32'h0000_0033, "R9");
    w0 = mem_wr_cnt; r0 = mem_rd_cnt;
    @(negedge clk_i); commit_i = 1;
    @(negedge clk_i); commit_i = 0;
    repeat (6) @(negedge clk_i);
    chk(mem_wr_cnt == w0 && mem_rd_cnt == r0, "R9 commit no traffic",
        64'(mem_wr_cnt + mem_rd_cnt), 64'(w0 + r0));
    do_abort(0);
    chk(rq_addr.size() == 0, "R9 nothing after commit", 64'(rq_addr.size()), 0);
    log_line(16'h0400, 32'h0000_0041, "R9");
    log_line(16'h0440, 32'h0000_0042, "R9");
    log_line(16'h0480, 32'h0000_0043, "R9");
    chk(sw_mem[int'(BASE)] == 32'h0000_0043, "R9 pointer reset", 64'(sw_mem[int'(BASE)]), 64'h43);
    @(negedge clk_i); commit_i = 1;
    @(negedge clk_i); commit_i = 0;
  endtask

  task automatic t_abort_wins;
    log_line(16'h0500, 32'h0000_0055, "R10");
    do_abort(1);
    chk(rq_addr.size() == 1, "R10 abort wins", 64'(rq_addr.size()), 1);
    if (rq_addr.size() == 1)
      chk(rq_data[0] == 32'h55, "R10 restored value", 64'(rq_data[0]), 64'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_fill_spill_rollback();
    t_commit();
    t_abort_wins();
    repeat (4) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule